// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block is the receive-side DMA engine of a simple Ethernet MAC. Software builds a ring of two-word descriptors in memory and writes the ring's base address. The first word of each descriptor is a buffer pointer. Its two low bits are flags: bit 0 is the ownership flag and bit 1 is the wrap flag. The second word is a status word that the engine fills in. When a frame starts on the byte-stream input, the engine reads the pointer word of the current descriptor.

- If the ownership flag is set, the buffer still belongs to software. The engine discards the whole frame and raises the buffer-not-available flag.
- Otherwise the engine packs the bytes into 32-bit words and stores them at the buffer pointer, with the two flag bits cleared. It then writes the status word, holding the length including the FCS, and writes the pointer word back with the ownership flag set. This hands the buffer to the CPU and raises the receive-complete flag.

The engine moves to the next descriptor after a completed frame. After a descriptor whose wrap flag is set, it returns to the ring base.

The memory port is a single master port with no stall. A write completes in the cycle it is issued. Read data returns in the cycle after the request. Frames are assumed to be separated by at least three idle cycles, which an Ethernet inter-frame gap always gives. Reading the interrupt status clears the pending flags. Dropping the receive enable stops the engine and reloads its pointer from the ring-base input.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset, and in every cycle in which `rx_en` is low, `mem_req` is 0 and input bytes are ignored; after reset `irq_pend` is 0.
- R2: The first byte of a frame, presented while the engine is idle, causes a read of the current descriptor's pointer word in that same cycle; the cycle after that read carries no memory request.
- R3: Frame bytes are packed little-endian (byte k of a word in bits [8k+7:8k]); each full word is written with `mem_be`=4'hF in the cycle its fourth byte arrives, at the buffer pointer with bits [1:0] cleared plus the byte offset.
- R4: After the last byte, the engine writes in consecutive cycles: any partial word (byte enables set only for the filled lanes), then the status word at descriptor+4 (length in bits [10:0], including FCS), then the pointer word at the descriptor with bit 0 set.
- R5: `irq_pend[0]` (receive complete) becomes 1 in the cycle after the pointer-word write-back.
- R6: After a completed frame, the next descriptor is the current one plus 8, or the ring base if the used descriptor had bit 1 set.
- R7: If the fetched pointer word has bit 0 set, the frame is dropped whole: no writes occur, the descriptor pointer does not advance, and `irq_pend[1]` (buffer not available) becomes 1 two cycles after the first byte.
- R8: Bytes beyond `BUF_BYTES` are not written; the status length then equals `BUF_BYTES` and status bit 11 is set (bit 11 is 0 otherwise).
- R9: A frame whose last byte carries `in_err` gets no status or pointer write-back and no interrupt, and the descriptor pointer does not advance.
- R10: `isr_rd` high in a cycle clears both pending flags from the next cycle on, except a flag being set in that same cycle, which stays set.
- R11: Lowering and raising `rx_en` restarts the engine at the value of `ring_base`.
- R12: `irq` is high exactly when a pending flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_en | input | 1 | Receive enable; low holds the engine idle at the ring base |
| ring_base | input | AW | Address of the first descriptor (8-byte aligned) |
| in_valid | input | 1 | Frame byte valid |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Marks the last byte of a frame |
| in_err | input | 1 | Error flag, meaningful with `in_last` |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | AW | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte enables for writes |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| isr_rd | input | 1 | Interrupt status read; clears pending flags |
| irq_pend | output | 2 | Pending flags: bit 0 receive complete, bit 1 buffer not available |
| irq | output | 1 | Interrupt request |

## Verification
Each result arrives a fixed number of cycles after the stimulus. A frame whose first byte arrives in cycle s has its descriptor read in cycle s, and a full word is written in the cycle of its fourth byte. The closing writes fall in cycles f, f+1 and f+2, where f is s plus the larger of the frame length and 2. Receive-complete is seen in cycle f+3, and buffer-not-available in cycle s+2. When a frame starts, the bench model works out every expected bus operation and flag change from its own copy of the memory and ring pointer, and files each one under its cycle number. At every falling edge it then compares the bus and the flags against that schedule, and any cycle with no expected operation must show an idle bus.

// File: rtl/rxr_pkg.sv
// Shared types and field positions of the receive descriptor ring writer.
package rxr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHK,
        ST_RECV,
        ST_DROP,
        ST_FLUSH,
        ST_STAT,
        ST_ADDR
    } rxr_state_e;

    localparam int FLAG_RCOMP = 0;
    localparam int FLAG_BNA   = 1;
    localparam int NUM_FLAGS  = 2;
    localparam int OWN_BIT    = 0;
    localparam int WRAP_BIT   = 1;
    localparam int LEN_W      = 11;
    localparam int OVF_BIT    = 11;
endpackage

// File: rtl/rxr_byte_pack.sv
// Byte-to-word packer. Collects frame bytes little-endian into a 32-bit
// word, counts the bytes stored and flags bytes lost beyond the buffer size.
// Assumes: 'first' marks the first byte of a frame; BUF_BYTES is a multiple of 4.
module rxr_byte_pack #(
    parameter int BUF_BYTES = 1536,
    parameter int CW        = $clog2(BUF_BYTES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic          first,
    input  logic [7:0]    din,
    output logic [CW-1:0] count,
    output logic [31:0]   word_out,
    output logic          full_wr,
    output logic          trunc
);
    localparam logic [CW-1:0] LIMIT = CW'(BUF_BYTES);

    logic [CW-1:0] cnt_q;
    logic [31:0]   word_q;
    logic          trunc_q;
    logic [CW-1:0] eff_cnt;
    logic          room;
    int            lane_i;

    // Present word including the byte taken this cycle.
    always_comb begin
        eff_cnt  = first ? '0 : cnt_q;
        room     = eff_cnt < LIMIT;
        lane_i   = int'(eff_cnt[1:0]);
        word_out = first ? '0 : word_q;
        if (take && room) begin
            word_out[8*lane_i +: 8] = din;
        end
        full_wr  = take && room && (eff_cnt[1:0] == 2'd3);
    end

    // Byte count, word assembly and truncation state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            word_q  <= '0;
            trunc_q <= 1'b0;
        end else if (take) begin
            cnt_q   <= room ? eff_cnt + CW'(1) : eff_cnt;
            word_q  <= word_out;
            trunc_q <= (first ? 1'b0 : trunc_q) | !room;
        end
    end

    assign count = cnt_q;
    assign trunc = trunc_q;
endmodule

// File: rtl/rxr_irq_flags.sv
// Sticky interrupt flags. A set pulse makes a flag pending; a status read
// clears all flags, but a set in the same cycle wins.
module rxr_irq_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic         clr,
    output logic [N-1:0] pend
);
    for (genvar g = 0; g < N; g++) begin : g_flag
        // One pending bit: set has priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n)       pend[g] <= 1'b0;
            else if (set[g])  pend[g] <= 1'b1;
            else if (clr)     pend[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/rx_ring_writer.sv
// Receive descriptor ring writer. Fetches the current descriptor on the
// first byte of a frame. If software still owns it, the frame is dropped.
// Otherwise the bytes are stored in the buffer, then the status and pointer
// words are written back, handing the buffer to the CPU.
// Assumes: memory writes take effect in one cycle; read data returns the
// next cycle; frames are at least three idle cycles apart; ring_base is
// 8-byte aligned.
module rx_ring_writer
    import rxr_pkg::*;
#(
    parameter int AW        = 32,
    parameter int BUF_BYTES = 1536
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_en,
    input  logic [AW-1:0] ring_base,
    input  logic          in_valid,
    input  logic [7:0]    in_data,
    input  logic          in_last,
    input  logic          in_err,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    output logic [3:0]    mem_be,
    input  logic [31:0]   mem_rdata,
    input  logic          isr_rd,
    output logic [1:0]    irq_pend,
    output logic          irq
);
    localparam int CW = $clog2(BUF_BYTES + 1);

    rxr_state_e    state;
    logic [AW-1:0] ptr_q;
    logic [31:0]   desc_q;
    logic          done_q, bad_q;

    logic          take, first, last_now, done_now, bad_now, owned;
    logic [CW-1:0] cnt;
    logic [31:0]   word;
    logic          full_wr, trunc;
    logic [AW-1:0] buf_base, word_addr;
    logic [3:0]    part_be;
    logic [31:0]   stat_word;
    logic [NUM_FLAGS-1:0] flag_set;

    // Byte acceptance and end-of-frame decode.
    always_comb begin
        take     = rx_en && in_valid &&
                   (state == ST_IDLE || state == ST_CHK || state == ST_RECV);
        first    = (state == ST_IDLE);
        last_now = take && in_last;
        done_now = done_q || last_now;
        bad_now  = bad_q || (last_now && in_err);
        owned    = mem_rdata[OWN_BIT];
    end

    rxr_byte_pack #(.BUF_BYTES(BUF_BYTES), .CW(CW)) pack_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .first    (first),
        .din      (in_data),
        .count    (cnt),
        .word_out (word),
        .full_wr  (full_wr),
        .trunc    (trunc)
    );

    // Buffer addressing, partial-word enables and status word.
    always_comb begin
        buf_base  = {desc_q[AW-1:2], 2'b00};
        word_addr = buf_base + AW'({cnt[CW-1:2], 2'b00});
        for (int k = 0; k < 4; k++) begin
            part_be[k] = (k < int'(cnt[1:0]));
        end
        stat_word            = '0;
        stat_word[LEN_W-1:0] = LEN_W'(cnt);
        stat_word[OVF_BIT]   = trunc;
    end

    // Memory port: one operation per cycle, chosen by the state.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = ptr_q;
        mem_wdata = word;
        mem_be    = 4'hF;
        if (rx_en) begin
            case (state)
                ST_IDLE:  mem_req = in_valid;
                ST_RECV: begin
                    mem_req  = full_wr;
                    mem_we   = 1'b1;
                    mem_addr = word_addr;
                end
                ST_FLUSH: begin
                    mem_req  = (cnt[1:0] != 2'b00);
                    mem_we   = 1'b1;
                    mem_addr = word_addr;
                    mem_be   = part_be;
                end
                ST_STAT: begin
                    mem_req   = 1'b1;
                    mem_we    = 1'b1;
                    mem_addr  = ptr_q + AW'(4);
                    mem_wdata = stat_word;
                end
                ST_ADDR: begin
                    mem_req   = 1'b1;
                    mem_we    = 1'b1;
                    mem_wdata = desc_q | 32'h1;
                end
                default: mem_req = 1'b0;
            endcase
        end
    end

    // Frame sequencing and ring pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            ptr_q  <= '0;
            desc_q <= '0;
            done_q <= 1'b0;
            bad_q  <= 1'b0;
        end else if (!rx_en) begin
            state  <= ST_IDLE;
            ptr_q  <= ring_base;
            done_q <= 1'b0;
            bad_q  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (take) begin
                    done_q <= last_now;
                    bad_q  <= last_now && in_err;
                    state  <= ST_CHK;
                end
                ST_CHK: begin
                    done_q <= done_now;
                    bad_q  <= bad_now;
                    if (owned) begin
                        state <= done_now ? ST_IDLE : ST_DROP;
                    end else begin
                        desc_q <= mem_rdata;
                        if (!done_now)    state <= ST_RECV;
                        else if (bad_now) state <= ST_IDLE;
                        else              state <= ST_FLUSH;
                    end
                end
                ST_RECV:  if (last_now) state <= in_err ? ST_IDLE : ST_FLUSH;
                ST_DROP:  if (in_valid && in_last) state <= ST_IDLE;
                ST_FLUSH: state <= ST_STAT;
                ST_STAT:  state <= ST_ADDR;
                ST_ADDR: begin
                    ptr_q <= desc_q[WRAP_BIT] ? ring_base : ptr_q + AW'(8);
                    state <= ST_IDLE;
                end
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Interrupt flag set conditions.
    always_comb begin
        flag_set             = '0;
        flag_set[FLAG_RCOMP] = rx_en && (state == ST_ADDR);
        flag_set[FLAG_BNA]   = rx_en && (state == ST_CHK) && owned;
    end

    rxr_irq_flags #(.N(NUM_FLAGS)) flags_i (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (flag_set),
        .clr   (isr_rd),
        .pend  (irq_pend)
    );

    assign irq = |irq_pend;
endmodule

// File: rtl/rxr_checker.sv
// Port-level temporal checks for the receive descriptor ring writer.
module rxr_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_en,
    input logic       mem_req,
    input logic       mem_we,
    input logic [1:0] mem_alo,
    input logic       mem_wd0,
    input logic       isr_rd,
    input logic [1:0] irq_pend
);
    // R1
    rx_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |-> !mem_req);

    // R3
    word_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_alo == 2'b00));

    // R2
    fetch_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |=> !mem_req);

    // R5
    rcomp_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_pend[0]) |-> $past(mem_req && mem_we && mem_wd0));

    // R7
    bna_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_pend[1]) |-> ($past(!mem_req) && $past(mem_req && !mem_we, 2)));

    // R10
    status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (isr_rd && !(mem_req && mem_we)) |=> !irq_pend[0]);
endmodule

bind rx_ring_writer rxr_checker chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_en    (rx_en),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_alo  (mem_addr[1:0]),
    .mem_wd0  (mem_wdata[0]),
    .isr_rd   (isr_rd),
    .irq_pend (irq_pend)
);

// File: tb/rx_ring_writer_tb_top.sv
// Bench: behavioural memory, per-frame schedule of expected bus operations
// and flag events, compared at every falling edge.
module rx_ring_writer_tb_top;
    localparam int BUF  = 64;
    localparam int BASE = 32'h100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_en = 1'b0;
    logic [31:0] ring_base = BASE;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_last = 1'b0;
    logic        in_err = 1'b0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [3:0]  mem_be;
    logic [31:0] mem_rdata = 32'h0;
    logic        isr_rd = 1'b0;
    logic [1:0]  irq_pend;
    logic        irq;

    always #4 clk = ~clk;

    rx_ring_writer #(.AW(32), .BUF_BYTES(BUF)) dut_i (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .ring_base(ring_base),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_err(in_err),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_rdata(mem_rdata),
        .isr_rd(isr_rd), .irq_pend(irq_pend), .irq(irq)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit chk_on = 1'b0;
    bit finished = 1'b0;
    string cur_tag = "R1 idle bus";

    logic [31:0] mem [int];
    bit          e_we [int];
    logic [31:0] e_addr [int];
    logic [31:0] e_data [int];
    logic [3:0]  e_be [int];
    string       e_tag [int];
    bit          rc_at [int];
    bit          bna_at [int];
    logic [1:0]  m_pend = 2'b00;
    bit          clr_prev = 1'b0;
    int          m_ptr = BASE;

    function automatic logic [31:0] mrd(int a);
        return mem.exists(a >> 2) ? mem[a >> 2] : 32'h0;
    endfunction

    function automatic logic [7:0] bval(int seed, int i);
        return 8'((seed * 16 + i * 5 + 1) & 255);
    endfunction

    // Memory model: writes with byte enables, reads return next cycle.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_req && mem_we) begin
            logic [31:0] w;
            w = mrd(int'(mem_addr));
            for (int k = 0; k < 4; k++) if (mem_be[k]) w[8*k +: 8] = mem_wdata[8*k +: 8];
            mem[int'(mem_addr >> 2)] = w;
        end else if (mem_req) begin
            mem_rdata <= mrd(int'(mem_addr));
        end
    end

    // Per-cycle comparison against the schedule.
    always @(negedge clk) begin
        if (chk_on && !finished) begin
            logic [31:0] msk;
            checks++;
            if (e_addr.exists(cyc)) begin
                for (int k = 0; k < 4; k++) msk[8*k +: 8] = {8{e_be[cyc][k]}};
                if (!mem_req || mem_we != e_we[cyc] || mem_addr != e_addr[cyc] ||
                    (e_we[cyc] && (mem_be != e_be[cyc] ||
                                   (mem_wdata & msk) != (e_data[cyc] & msk)))) begin
                    errors++;
                    $display("FAIL %s cycle %0d: req=%0b we=%0b addr=%h data=%h be=%h expected we=%0b addr=%h data=%h be=%h",
                             e_tag[cyc], cyc, mem_req, mem_we, mem_addr, mem_wdata, mem_be,
                             e_we[cyc], e_addr[cyc], e_data[cyc], e_be[cyc]);
                end
            end else if (mem_req) begin
                errors++;
                $display("FAIL %s cycle %0d: req=1 we=%0b addr=%h expected no request",
                         cur_tag, cyc, mem_we, mem_addr);
            end
            if (clr_prev) m_pend = 2'b00;
            if (rc_at.exists(cyc)) m_pend[0] = 1'b1;
            if (bna_at.exists(cyc)) m_pend[1] = 1'b1;
            clr_prev = isr_rd;
            checks++;
            if (irq_pend[0] != m_pend[0]) begin
                errors++;
                $display("FAIL R5 R10 receive-complete flag cycle %0d: got %0b expected %0b",
                         cyc, irq_pend[0], m_pend[0]);
            end
            checks++;
            if (irq_pend[1] != m_pend[1]) begin
                errors++;
                $display("FAIL R7 R10 buffer-not-available flag cycle %0d: got %0b expected %0b",
                         cyc, irq_pend[1], m_pend[1]);
            end
            checks++;
            if (irq != |m_pend) begin
                errors++;
                $display("FAIL R12 irq line cycle %0d: got %0b expected %0b", cyc, irq, |m_pend);
            end
        end
    end

    task automatic tick(int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic exp_op(int c, bit we, int addr, logic [31:0] d, logic [3:0] be, string tag);
        e_we[c] = we; e_addr[c] = addr; e_data[c] = d; e_be[c] = be; e_tag[c] = tag;
    endtask

    task automatic drive_bytes(int n, bit err, int seed);
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b1;
            in_data  = bval(seed, i);
            in_last  = (i == n - 1);
            in_err   = err && (i == n - 1);
            tick(1);
        end
        in_valid = 1'b0; in_last = 1'b0; in_err = 1'b0;
    endtask

    // Schedules every expected effect of a frame, then drives it.
    task automatic send_frame(int n, bit err, int seed);
        int s, p, bptr, m, f;
        logic [31:0] a, d;
        s = cyc;
        p = m_ptr;
        a = mrd(p);
        exp_op(s, 1'b0, p, 32'h0, 4'h0, "R2 R6 R11 descriptor read");
        if (a[0]) begin
            bna_at[s + 2] = 1'b1;
            cur_tag = "R7 dropped frame";
        end else begin
            bptr = int'(a & 32'hFFFF_FFFC);
            m = (n < BUF) ? n : BUF;
            cur_tag = err ? "R9 error frame" : (n > BUF ? "R8 truncated frame" : "R3 frame data");
            for (int i = 3; i < m; i += 4) begin
                d = {bval(seed, i), bval(seed, i - 1), bval(seed, i - 2), bval(seed, i - 3)};
                exp_op(s + i, 1'b1, bptr + i - 3, d, 4'hF, "R3 R8 data word");
            end
            if (!err) begin
                f = s + ((n > 2) ? n : 2);
                if (m % 4 != 0) begin
                    d = 32'h0;
                    for (int j = 0; j < m % 4; j++) d[8*j +: 8] = bval(seed, (m & ~3) + j);
                    exp_op(f, 1'b1, bptr + (m & ~3), d, 4'((1 << (m % 4)) - 1), "R4 partial word");
                end
                exp_op(f + 1, 1'b1, p + 4, ((n > BUF) ? 32'h800 : 32'h0) | 32'(m),
                       4'hF, "R4 R8 status word");
                exp_op(f + 2, 1'b1, p, a | 32'h1, 4'hF, "R4 pointer word");
                rc_at[f + 3] = 1'b1;
                m_ptr = a[1] ? int'(ring_base) : p + 8;
            end
        end
        drive_bytes(n, err, seed);
    endtask

    task automatic report;
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Watchdog: a hung run is a failure.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        report();
    end

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(1);
        checks++;
        if (mem_req !== 1'b0 || irq_pend !== 2'b00) begin
            errors++;
            $display("FAIL R1 reset state: req=%0b pend=%b expected 0 and 00", mem_req, irq_pend);
        end
        chk_on = 1'b1;
        cur_tag = "R1 disabled";
        drive_bytes(5, 1'b0, 9);
        tick(3);
        mem[BASE >> 2]       = 32'h1000;
        mem[(BASE + 8) >> 2] = 32'h2000;
        mem[(BASE + 16) >> 2] = 32'h3002;
        rx_en = 1'b1;
        m_ptr = BASE;
        tick(2);
        send_frame(10, 1'b0, 1); tick(6);
        isr_rd = 1'b1; tick(1); isr_rd = 1'b0; tick(3);
        send_frame(1, 1'b0, 2); tick(5);
        send_frame(2, 1'b0, 3); tick(5);
        send_frame(4, 1'b0, 4); tick(5);
        send_frame(5, 1'b0, 5); tick(5);
        isr_rd = 1'b1; tick(1); isr_rd = 1'b0; tick(2);
        mem[BASE >> 2]       = 32'h1000;
        mem[(BASE + 8) >> 2] = 32'h2000;
        mem[(BASE + 16) >> 2] = 32'h3002;
        send_frame(70, 1'b0, 6); tick(5);
        send_frame(6, 1'b1, 7); tick(5);
        send_frame(8, 1'b0, 8); tick(5);
        isr_rd = 1'b1;
        send_frame(3, 1'b0, 10); tick(8);
        isr_rd = 1'b0; tick(2);
        mem[BASE >> 2] = 32'h1000;
        send_frame(7, 1'b0, 11); tick(5);
        cur_tag = "R1 R11 restart";
        rx_en = 1'b0; tick(3);
        mem[BASE >> 2] = 32'h1000;
        rx_en = 1'b1; m_ptr = BASE; tick(2);
        send_frame(9, 1'b0, 12); tick(5);
        rx_en = 1'b0;
        ring_base = 32'h200;
        mem[32'h200 >> 2] = 32'h4002;
        tick(3);
        rx_en = 1'b1; m_ptr = 32'h200; tick(2);
        send_frame(12, 1'b0, 13); tick(5);
        send_frame(5, 1'b0, 14); tick(8);
        report();
    end
endmodule